// File: doc/BRIEF.md
# I2S Audio Serializer with Mute, Pause and Mono

This block turns a stream of parallel audio samples into a two-channel serial audio stream and rebuilds the incoming serial stream into parallel samples. A bit-period strobe, made elsewhere from the serial clock, advances a slot counter. The counter alternates a left and a right channel, each a fixed number of bit periods long. The word-select line shows the current channel and runs on the pin that otherwise serves as slave select. Transmit samples come from a FIFO through a valid/pop pair. Received samples leave through a one-cycle valid strobe with a channel flag.

Four run-time controls shape the stream. Mute keeps consuming samples but sends zeros. Pause freezes FIFO traffic in both directions and sends zeros. Mono sends one sample on both channels and keeps only left-channel receive words. Left-justify moves the first data bit from the second bit period of a channel to the first. Clearing the enable returns every output to its low idle state within one clock.

Top module: `i2s_audio_port`

## Requirements
- R1: While the enable is low, word select, serial data and the receive strobe are low one clock later, no sample is popped, and the first strobe after enabling opens a left channel.
- R2: Word select is low for the left channel and high for the right channel, each channel lasts SLOT_BITS strobes, and it changes only on a strobe.
- R3: With left-justify off, the most significant bit of a word is sent in the second bit period of its channel and the rest follow MSB first. Every other bit period of the channel carries zero.
- R4: With left-justify on, the most significant bit is sent in the first bit period of its channel.
- R5: The word-length code n selects n data bits, and code 0 selects DATA_W bits. A transmit sample uses its n least significant bits, and a received word is returned right-aligned with the upper bits zero.
- R6: In stereo mode one sample is popped at the start of each channel, so the left word is followed by the next sample on the right.
- R7: In mono mode one sample is popped per left channel and the same word is sent again on the right channel.
- R8: While mute is set, the data line carries only zeros, but samples are still popped at the normal rate.
- R9: While pause is set, the data line carries zeros, no sample is popped and no receive word is delivered.
- R10: Each received word raises the receive strobe for exactly one clock, one strobe per channel in stereo. The channel flag is 0 for a left word and 1 for a right word.
- R11: In mono mode only left-channel words are delivered, and right-channel receive data is discarded.
- R12: If no sample is available at the start of a channel, that channel sends zeros and nothing is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_en | input | 1 | Block enable; low forces idle |
| i_mute | input | 1 | Send zeros, keep popping |
| i_pause | input | 1 | Send zeros, stop FIFO traffic |
| i_mono | input | 1 | One sample serves both channels |
| i_lj | input | 1 | Left-justified timing |
| i_wlen | input | $clog2(DATA_W) | Word-length code, 0 means DATA_W |
| i_bclk_tick | input | 1 | One-clock strobe per bit period |
| i_tx_data | input | DATA_W | Head-of-FIFO transmit sample |
| i_tx_valid | input | 1 | Transmit sample available |
| o_tx_pop | output | 1 | Pops the transmit sample |
| o_ws | output | 1 | Word select |
| o_sd | output | 1 | Serial data out |
| i_sd | input | 1 | Serial data in |
| o_rx_data | output | DATA_W | Received word, right-aligned |
| o_rx_valid | output | 1 | Received word strobe |
| o_rx_right | output | 1 | Received word came from the right channel |

## Verification
The sharpest overlap is mute against the FIFO pop. On the strobe that opens a channel, the block pops a sample and must drop it in the same cycle while the data line stays zero. In left-justified mode, the muted MSB and the pop share the same strobe. A muted stereo run, checked against the bench's word model, provokes this. The run passes only if every reassembled word is zero and the pop count still equals the number of channels. A second case overlaps the mono right-channel reuse with the receive path, which must drop the right word in the very strobe where the transmit side repeats the left word.

// File: rtl/i2s_port_pkg.sv
package i2s_port_pkg;

  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

  typedef struct packed {
    logic mute;
    logic pause;
    logic mono;
    logic lj;
  } mode_t;

endpackage

// File: rtl/i2s_slot_timer.sv
module i2s_slot_timer
  import i2s_port_pkg::*;
#(
  parameter int SLOT_BITS = 32,
  parameter int CNT_W     = $clog2(SLOT_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i_en,
  input  logic             i_tick,
  output logic [CNT_W-1:0] o_pos,
  output chan_e            o_chan,
  output logic             o_ws
);

  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(SLOT_BITS - 1);

  logic [CNT_W-1:0] pos_q, pos_d;
  chan_e            chan_q, chan_d;
  logic             ws_q, ws_d;
  logic             upd;

  assign upd = ~i_en | i_tick;

  always_comb begin
    pos_d  = pos_q;
    chan_d = chan_q;
    ws_d   = ws_q;
    if (!i_en) begin
      pos_d  = '0;
      chan_d = CH_LEFT;
      ws_d   = 1'b0;
    end else if (i_tick) begin
      ws_d = (chan_q == CH_RIGHT);
      if (pos_q == LAST_POS) begin
        pos_d  = '0;
        chan_d = (chan_q == CH_LEFT) ? CH_RIGHT : CH_LEFT;
      end else begin
        pos_d = pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      chan_q <= CH_LEFT;
      ws_q   <= 1'b0;
    end else if (upd) begin
      pos_q  <= pos_d;
      chan_q <= chan_d;
      ws_q   <= ws_d;
    end
  end

  assign o_pos  = pos_q;
  assign o_chan = chan_q;
  assign o_ws   = ws_q;

  AST_WS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    i_en && !i_tick |=> $stable(o_ws)); // R2
  AST_WS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !i_en |=> !o_ws); // R1

endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
  import i2s_port_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5,
  parameter int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_en,
  input  logic              i_tick,
  input  logic [CNT_W-1:0]  i_pos,
  input  chan_e             i_chan,
  input  mode_t             i_mode,
  input  logic [LEN_W-1:0]  i_len,
  input  logic [DATA_W-1:0] i_tx_data,
  input  logic              i_tx_valid,
  output logic              o_tx_pop,
  output logic              o_sd
);

  logic [DATA_W-1:0] word_q, word_d, new_word, word_sel, shifted;
  logic              sd_q, sd_d;
  logic              at_start, reuse, in_rng;
  logic [CNT_W-1:0]  dly, off;
  logic [LEN_W-1:0]  bidx;

  assign at_start = i_en & i_tick & (i_pos == '0);
  assign reuse    = i_mode.mono & (i_chan == CH_RIGHT);
  assign o_tx_pop = at_start & ~i_mode.pause & ~reuse & i_tx_valid;

  always_comb begin
    if (i_mode.pause)   new_word = '0;
    else if (reuse)     new_word = word_q;
    else if (i_tx_valid) new_word = i_tx_data;
    else                new_word = '0;
  end

  assign word_sel = (i_pos == '0) ? new_word : word_q;
  assign dly      = i_mode.lj ? '0 : CNT_W'(1);
  assign off      = i_pos - dly;
  assign in_rng   = (i_pos >= dly) && (int'(off) < int'(i_len));
  assign bidx     = LEN_W'(int'(i_len) - 1 - int'(off));
  assign shifted  = word_sel >> bidx;

  always_comb begin
    word_d = word_q;
    sd_d   = sd_q;
    if (!i_en) begin
      word_d = '0;
      sd_d   = 1'b0;
    end else if (i_tick) begin
      sd_d = in_rng & shifted[0] & ~i_mode.mute & ~i_mode.pause;
      if (i_pos == '0) word_d = new_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      sd_q   <= 1'b0;
    end else if (~i_en | i_tick) begin
      word_q <= word_d;
      sd_q   <= sd_d;
    end
  end

  assign o_sd = sd_q;

  AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    i_en && i_tick && i_mode.mute |=> !o_sd); // R8
  AST_PAUSE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    i_en && i_tick && i_mode.pause |=> !o_sd); // R9
  AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    o_tx_pop |-> i_tx_valid && i_tick && i_en); // R12
  AST_MONO_RIGHT_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    i_mode.mono && i_chan == CH_RIGHT |-> !o_tx_pop); // R7
  AST_SD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !i_en |=> !o_sd); // R1

endmodule

// File: rtl/i2s_rx_deserializer.sv
module i2s_rx_deserializer
  import i2s_port_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5,
  parameter int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_en,
  input  logic              i_tick,
  input  logic [CNT_W-1:0]  i_pos,
  input  chan_e             i_chan,
  input  logic              i_lj,
  input  logic              i_mono,
  input  logic              i_pause,
  input  logic [LEN_W-1:0]  i_len,
  input  logic              i_sdi,
  output logic [DATA_W-1:0] o_rx_data,
  output logic              o_rx_valid,
  output logic              o_rx_right
);

  logic              pvld_q, pvld_d;
  logic [CNT_W-1:0]  ppos_q, ppos_d;
  chan_e             pchan_q, pchan_d;
  logic [DATA_W-2:0] sh_q, sh_d;
  logic [DATA_W-1:0] data_q, data_d, sh_next, mask;
  logic              valid_q, valid_d, right_q, right_d;
  logic [CNT_W-1:0]  dly, off;
  logic              in_rng, last_bit, keep;

  assign dly      = i_lj ? '0 : CNT_W'(1);
  assign off      = ppos_q - dly;
  assign in_rng   = pvld_q && (ppos_q >= dly) && (int'(off) < int'(i_len));
  assign last_bit = in_rng && (int'(off) == int'(i_len) - 1);
  assign sh_next  = {sh_q, i_sdi};
  assign mask     = {DATA_W{1'b1}} >> (LEN_W'(DATA_W) - i_len);
  assign keep     = ~i_pause & ~(i_mono & (pchan_q == CH_RIGHT));

  always_comb begin
    pvld_d  = pvld_q;
    ppos_d  = ppos_q;
    pchan_d = pchan_q;
    sh_d    = sh_q;
    data_d  = data_q;
    right_d = right_q;
    valid_d = 1'b0;
    if (!i_en) begin
      pvld_d  = 1'b0;
      ppos_d  = '0;
      pchan_d = CH_LEFT;
      sh_d    = '0;
    end else if (i_tick) begin
      pvld_d  = 1'b1;
      ppos_d  = i_pos;
      pchan_d = i_chan;
      if (in_rng) sh_d = sh_next[DATA_W-2:0];
      if (last_bit && keep) begin
        data_d  = sh_next & mask;
        right_d = (pchan_q == CH_RIGHT);
        valid_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pvld_q  <= 1'b0;
      ppos_q  <= '0;
      pchan_q <= CH_LEFT;
      sh_q    <= '0;
      data_q  <= '0;
      right_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (~i_en | i_tick) begin
        pvld_q  <= pvld_d;
        ppos_q  <= ppos_d;
        pchan_q <= pchan_d;
        sh_q    <= sh_d;
        data_q  <= data_d;
        right_q <= right_d;
      end
    end
  end

  assign o_rx_data  = data_q;
  assign o_rx_valid = valid_q;
  assign o_rx_right = right_q;

  AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    o_rx_valid |=> !o_rx_valid); // R10
  AST_RX_MONO_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    o_rx_valid && i_mono |-> !o_rx_right); // R11
  AST_RX_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    i_en && i_tick && i_pause |=> !o_rx_valid); // R9
  AST_RX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !i_en |=> !o_rx_valid); // R1

endmodule

// File: rtl/i2s_audio_port.sv
module i2s_audio_port
  import i2s_port_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SLOT_BITS = 32,
  localparam int WCODE_W  = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               i_en,
  input  logic               i_mute,
  input  logic               i_pause,
  input  logic               i_mono,
  input  logic               i_lj,
  input  logic [WCODE_W-1:0] i_wlen,
  input  logic               i_bclk_tick,
  input  logic [DATA_W-1:0]  i_tx_data,
  input  logic               i_tx_valid,
  output logic               o_tx_pop,
  output logic               o_ws,
  output logic               o_sd,
  input  logic               i_sd,
  output logic [DATA_W-1:0]  o_rx_data,
  output logic               o_rx_valid,
  output logic               o_rx_right
);

  localparam int CNT_W = $clog2(SLOT_BITS);
  localparam int LEN_W = $clog2(DATA_W + 1);

  logic [1:0]       rsync_q;
  logic             rst_sync_n;
  logic [CNT_W-1:0] pos;
  chan_e            chan;
  logic [LEN_W-1:0] len;
  mode_t            mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  assign len  = (i_wlen == '0) ? LEN_W'(DATA_W) : LEN_W'(i_wlen);
  assign mode = '{mute: i_mute, pause: i_pause, mono: i_mono, lj: i_lj};

  i2s_slot_timer #(.SLOT_BITS(SLOT_BITS), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .i_en(i_en), .i_tick(i_bclk_tick),
    .o_pos(pos), .o_chan(chan), .o_ws(o_ws)
  );

  i2s_tx_serializer #(.DATA_W(DATA_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_tx (
    .clk(clk), .rst_n(rst_sync_n), .i_en(i_en), .i_tick(i_bclk_tick),
    .i_pos(pos), .i_chan(chan), .i_mode(mode), .i_len(len),
    .i_tx_data(i_tx_data), .i_tx_valid(i_tx_valid),
    .o_tx_pop(o_tx_pop), .o_sd(o_sd)
  );

  i2s_rx_deserializer #(.DATA_W(DATA_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_rx (
    .clk(clk), .rst_n(rst_sync_n), .i_en(i_en), .i_tick(i_bclk_tick),
    .i_pos(pos), .i_chan(chan), .i_lj(i_lj), .i_mono(i_mono),
    .i_pause(i_pause), .i_len(len), .i_sdi(i_sd),
    .o_rx_data(o_rx_data), .o_rx_valid(o_rx_valid), .o_rx_right(o_rx_right)
  );

  AST_POP_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !i_en || i_pause |-> !o_tx_pop); // R9

endmodule

// File: tb/i2s_audio_port_bench.sv
`timescale 1ns/1ps
module i2s_audio_port_bench;

  localparam int DW   = 16;
  localparam int SLOT = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en, mute, pause, mono, lj, tick, tx_valid, sdi;
  logic [3:0]    wlen;
  logic [DW-1:0] tx_data;
  logic          tx_pop, ws, sd;
  logic [DW-1:0] rx_data;
  logic          rx_valid, rx_right;

  int n_cmp = 0;
  int n_bad = 0;
  int src_ptr = 0;
  int mdl_ptr = 0;
  int rx_n = 0;
  bit finished = 0;
  logic [DW-1:0] exp_tx[$];
  logic [DW:0]   exp_rx[$];

  always #2 clk = ~clk;

  i2s_audio_port u_i2s_audio_port (
    .clk(clk), .rst_n(rst_n), .i_en(en), .i_mute(mute), .i_pause(pause),
    .i_mono(mono), .i_lj(lj), .i_wlen(wlen), .i_bclk_tick(tick),
    .i_tx_data(tx_data), .i_tx_valid(tx_valid), .o_tx_pop(tx_pop),
    .o_ws(ws), .o_sd(sd), .i_sd(sdi), .o_rx_data(rx_data),
    .o_rx_valid(rx_valid), .o_rx_right(rx_right)
  );

  function automatic logic [DW-1:0] src_word(int i);
    return DW'((i * 40503) ^ 32'h5A3C);
  endfunction

  function automatic logic [DW-1:0] rx_word(int i);
    return DW'((i * 27961) ^ 32'hC3A5);
  endfunction

  assign tx_data = src_word(src_ptr);
  always @(posedge clk) if (tx_pop) src_ptr <= src_ptr + 1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Receive monitor: pops the scoreboard as words come out
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (exp_rx.size() == 0) chk("R10 unexpected word", {15'd0, rx_right, rx_data}, 32'hFFFFFFFF);
      else chk("R10 rx word", {15'd0, rx_right, rx_data}, {15'd0, exp_rx.pop_front()});
    end
  end

  // Slot engine: drives strobes and serial input, checks serial output
  task automatic run_slots(string tag, int n, int len);
    int dly = lj ? 0 : 1;
    logic [DW-1:0] mask = (len == DW) ? '1 : DW'((1 << len) - 1);
    logic [DW-1:0] cur_tx = '0, acc = '0, cur_rx = '0;
    bit stray = 0;
    for (int k = 0; k < n; k++) begin
      int p = k % SLOT;
      int c = (k / SLOT) % 2;
      int off = p - dly;
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      if (p == 0) begin
        if (pause) cur_tx = '0;
        else if (mono && c == 1) cur_tx = cur_tx;
        else if (tx_valid) begin cur_tx = src_word(mdl_ptr) & mask; mdl_ptr++; end
        else cur_tx = '0;
        exp_tx.push_back((mute || pause) ? '0 : cur_tx);
        stray = 0;
        acc = '0;
      end
      if (ws !== c[0]) stray = 1;
      if (off >= 0 && off < len) begin
        acc = {acc[DW-2:0], sd};
        if (off == len - 1) chk({tag, " tx word"}, {16'd0, acc}, {16'd0, exp_tx.pop_front()});
      end else if (sd !== 1'b0) stray = 1;
      if (p == SLOT - 1) chk("R2 word select and idle bits", {31'd0, stray}, 32'd0);
      if (off == 0) begin
        cur_rx = rx_word(rx_n) & mask;
        rx_n++;
        if (!pause && !(mono && c == 1)) exp_rx.push_back({c[0], cur_rx});
      end
      sdi = (off >= 0 && off < len) ? cur_rx[len - 1 - off] : 1'b1;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic phase(string tag, logic [3:0] code, bit l, bit mo, bit mu, bit pa, bit v);
    int len = (code == 0) ? DW : int'(code);
    @(negedge clk);
    wlen = code; lj = l; mono = mo; mute = mu; pause = pa; tx_valid = v;
    @(negedge clk) en = 1'b1;
    run_slots(tag, 4 * SLOT, len);
    @(negedge clk) en = 1'b0;
    @(negedge clk);
    chk({tag, " pop count"}, src_ptr, mdl_ptr);
    chk({tag, " pending rx words"}, exp_rx.size(), 0);
  endtask

  initial begin
    rst_n = 1'b0; en = 0; mute = 0; pause = 0; mono = 0; lj = 0;
    tick = 0; tx_valid = 1; sdi = 0; wlen = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset outputs", {28'd0, ws, sd, rx_valid, tx_pop}, 32'd0);

    phase("R3 R6 stereo 16b", 4'd0, 0, 0, 0, 0, 1);
    phase("R4 R5 left-justified 5b", 4'd5, 1, 0, 0, 0, 1);
    phase("R5 single bit", 4'd1, 0, 0, 0, 0, 1);
    phase("R7 R11 mono 12b", 4'd12, 0, 1, 0, 0, 1);
    phase("R8 mute", 4'd8, 1, 0, 1, 0, 1);
    phase("R9 pause", 4'd0, 0, 0, 0, 1, 1);
    phase("R12 underrun", 4'd9, 0, 0, 0, 0, 0);

    // R1: disable in the middle of a right-channel word
    @(negedge clk);
    wlen = 4'd0; lj = 1; mono = 0; mute = 0; pause = 0; tx_valid = 1;
    @(negedge clk) en = 1'b1;
    run_slots("R1 mid-word", SLOT + 8, DW);
    chk("R2 right channel select", {31'd0, ws}, 32'd1);
    @(negedge clk) en = 1'b0;
    @(negedge clk);
    chk("R1 idle after disable", {29'd0, ws, sd, rx_valid}, 32'd0);
    exp_tx.delete();
    exp_rx.delete();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      chk("R1 strobes ignored while disabled", {29'd0, ws, sd, rx_valid}, 32'd0);
    end
    chk("R1 no pops while disabled", src_ptr, mdl_ptr);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule